// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital controller that sits beside a successive-approximation converter. It holds the settings software writes: the on/off switch, the start command, continuous mode, the input/gain selection, the reference selection and the result alignment. It counts ADC clock ticks to time each conversion, captures the converter's 10-bit value when a conversion ends, raises a completion flag, and presents the captured value in a 16-bit data word.

Two byte-wide registers are written through a simple strobe, address and data interface. Address 0 is the control register and address 1 is the selection register. A separate `adc_tick` input marks each ADC clock period, so the divider that produces it stays outside this block. Each conversion runs on the input and reference settings that were in force when it started. Settings written while a conversion is running go to the converter only at the next conversion boundary. The alignment setting does not wait for a boundary: it applies to the output word at once.

Top module: `adc_seq`

## Requirements
- R1: After reset, the control readback, the selection readback, the data word, `busy`, `act_mux` and `act_ref` are all zero.
- R2: The control register uses bit 0 for enable, bit 1 for start, bit 2 for continuous mode and bit 3 for the done flag. In single mode, with enable set, writing 1 to start begins one conversion. Start and `busy` read 1 while that conversion runs and read 0 once it completes. An ordinary conversion takes 13 ADC ticks.
- R3: The next conversion takes 25 ADC ticks, instead of 13, in two cases: it is the first conversion after enable goes from 0 to 1, or the reference field has been changed since the last conversion began.
- R4: The selection register uses bits 4:0 for the input select, bits 6:5 for the reference select and bit 7 for alignment. Its readback follows a write at once. `act_mux` and `act_ref` hold the values latched at the start of the running conversion, and a write during that conversion neither changes them nor changes its length. While the block is idle, `act_mux` and `act_ref` follow the register.
- R5: With alignment 0, the result sits in bits 9:0 of the data word and the upper bits are 0. With alignment 1, the result sits in bits 15:6 and the lower bits are 0.
- R6: Changing the alignment bit changes the data word on the next cycle, even while a conversion is running. The stored result is not changed.
- R7: Writing enable 0 stops any running conversion at once. `busy` and start go to 0, the done flag is not set, and the stored result stays as it was.
- R8: In continuous mode, one write of start launches a conversion. Each later conversion begins on the same cycle the previous one completes. Start and `busy` stay 1, and every completion sets the done flag and stores a new result.
- R9: Clearing continuous mode lets the running conversion finish and store its result. No further conversion starts, and start then reads 0.
- R10: Writing 0 to the start bit has no effect on a running conversion.
- R11: The done flag is set on the same cycle the result is stored. Writing 1 to bit 3 of the control register clears it.
- R12: A start write whose enable bit is 0 is ignored. No conversion begins and the done flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_tick | input | 1 | One pulse per ADC clock period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control register, 1 = selection register |
| wr_data | input | 8 | Register write data |
| conv_value | input | 10 | Converter output, captured at the end of a conversion |
| ctrl_rd | output | 8 | Control register readback |
| sel_rd | output | 8 | Selection register readback |
| data_out | output | 16 | Aligned result word |
| busy | output | 1 | A conversion is running |
| act_mux | output | 5 | Input select applied to the converter |
| act_ref | output | 2 | Reference select applied to the converter |

## Verification
The bench measures each conversion's length in clock cycles from the start write to the done flag. A design that failed to lengthen the first conversion after enable, or the first conversion after a reference change, would report 13 where 25 is expected. A design that applied a mid-conversion selection write at once would lengthen or re-route the running conversion, which shows up as a wrong cycle count or a wrong `act_mux` value. The bench also toggles alignment during a conversion, clears enable partway through, writes start as 0 while busy, and clears continuous mode partway through a conversion. A controller that latched alignment at conversion end, set the done flag on an abort, stopped on a zero start write, or launched one conversion too many would each be caught by a data-word, flag or count mismatch.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    // control register bit positions (software visible)
    localparam int CTRL_EN = 0;
    localparam int CTRL_ST = 1;
    localparam int CTRL_FR = 2;
    localparam int CTRL_DN = 3;
    localparam int CTRL_W  = 4;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_SEL  = 1'b1;
endpackage

// File: rtl/adc_sel_regs.sv
module adc_sel_regs #(
    parameter int MUX_W = 5,
    parameter int REF_W = 2,
    localparam int SEL_W = MUX_W + REF_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_wr,
    input  logic [SEL_W-1:0] wr_data,
    output logic [MUX_W-1:0] mux_q,
    output logic [REF_W-1:0] ref_q,
    output logic             align_q,
    output logic [MUX_W-1:0] mux_nx,
    output logic [REF_W-1:0] ref_nx,
    output logic             ref_chg
);
    typedef struct packed {
        logic [MUX_W-1:0] mux;
        logic [REF_W-1:0] rf;
        logic             align;
    } sel_t;

    sel_t sel_d, sel_q;

    always_comb begin
        sel_d   = sel_q;
        ref_chg = 1'b0;
        if (sel_wr) begin
            sel_d.mux   = wr_data[MUX_W-1:0];
            sel_d.rf    = wr_data[MUX_W +: REF_W];
            sel_d.align = wr_data[MUX_W + REF_W];
            ref_chg     = (wr_data[MUX_W +: REF_W] != sel_q.rf);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    assign mux_q   = sel_q.mux;
    assign ref_q   = sel_q.rf;
    assign align_q = sel_q.align;
    assign mux_nx  = sel_d.mux;
    assign ref_nx  = sel_d.rf;

    // a reported reference change must leave a different stored reference
    p_refchg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ref_chg |=> (ref_q != $past(ref_q)));
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int RES_W    = 10,
    parameter int MUX_W    = 5,
    parameter int REF_W    = 2,
    parameter int NORM_CYC = 13,
    parameter int LONG_CYC = 25,
    localparam int CNT_W   = $clog2(LONG_CYC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic [RES_W-1:0]  conv_value,
    input  logic [MUX_W-1:0]  mux_nx,
    input  logic [REF_W-1:0]  ref_nx,
    input  logic              ref_chg,
    output logic              en,
    output logic              free,
    output logic              start,
    output logic              done,
    output logic              busy,
    output logic [RES_W-1:0]  result,
    output logic [MUX_W-1:0]  act_mux,
    output logic [REF_W-1:0]  act_ref
);
    localparam logic [CNT_W-1:0] LAST_NORM = CNT_W'(NORM_CYC - 1);
    localparam logic [CNT_W-1:0] LAST_LONG = CNT_W'(LONG_CYC - 1);

    typedef struct packed {
        logic             en;
        logic             free;
        logic             start;
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             len_long;
        logic             long_pend;
        logic             done;
        logic [RES_W-1:0] result;
        logic [MUX_W-1:0] act_mux;
        logic [REF_W-1:0] act_ref;
    } seq_t;

    seq_t seq_d, seq_q;
    logic en_nx, fr_nx, finish, launch;
    logic [CNT_W-1:0] last;

    always_comb begin
        seq_d  = seq_q;
        launch = 1'b0;
        en_nx  = ctrl_wr ? ctrl_wdata[CTRL_EN] : seq_q.en;
        fr_nx  = ctrl_wr ? ctrl_wdata[CTRL_FR] : seq_q.free;
        seq_d.en   = en_nx;
        seq_d.free = fr_nx;
        if (ref_chg) seq_d.long_pend = 1'b1;
        if (ctrl_wr && ctrl_wdata[CTRL_DN]) seq_d.done = 1'b0;
        last   = seq_q.len_long ? LAST_LONG : LAST_NORM;
        finish = seq_q.busy && tick && (seq_q.cnt == last);

        if (!en_nx) begin
            // switched off: abort and arm the long first conversion
            seq_d.busy      = 1'b0;
            seq_d.start     = 1'b0;
            seq_d.cnt       = '0;
            seq_d.long_pend = 1'b1;
        end else begin
            if (finish) begin
                seq_d.result = conv_value;
                seq_d.done   = 1'b1;
                if (fr_nx) begin
                    launch = 1'b1;
                end else begin
                    seq_d.busy  = 1'b0;
                    seq_d.start = 1'b0;
                end
            end else if (seq_q.busy) begin
                if (tick) seq_d.cnt = seq_q.cnt + 1'b1;
            end else if (ctrl_wr && ctrl_wdata[CTRL_ST]) begin
                launch = 1'b1;
            end

            if (launch) begin
                seq_d.busy      = 1'b1;
                seq_d.start     = 1'b1;
                seq_d.cnt       = '0;
                seq_d.len_long  = seq_q.long_pend | ref_chg;
                seq_d.long_pend = 1'b0;
            end
        end

        // converter settings move only at a boundary or while idle
        if (launch || !seq_d.busy) begin
            seq_d.act_mux = mux_nx;
            seq_d.act_ref = ref_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q           <= '0;
            seq_q.long_pend <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign en      = seq_q.en;
    assign free    = seq_q.free;
    assign start   = seq_q.start;
    assign done    = seq_q.done;
    assign busy    = seq_q.busy;
    assign result  = seq_q.result;
    assign act_mux = seq_q.act_mux;
    assign act_ref = seq_q.act_ref;

    p_act_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.busy && seq_q.cnt != '0) |->
            (seq_q.act_mux == $past(seq_q.act_mux) && seq_q.act_ref == $past(seq_q.act_ref)));

    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.busy |-> (seq_q.cnt < CNT_W'(LONG_CYC)));

    p_off_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_q.en |-> (!seq_q.busy && !seq_q.start));

    p_busy_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.busy |-> seq_q.start);

    p_single_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && en_nx && !fr_nx) |=> (!seq_q.start && !seq_q.busy));

    p_done_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && en_nx) |=> seq_q.done);

    p_free_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && en_nx && fr_nx) |=> (seq_q.busy && seq_q.start && seq_q.cnt == '0));
endmodule

// File: rtl/adc_res_align.sv
module adc_res_align #(
    parameter int RES_W = 10,
    parameter int OUT_W = 16
) (
    input  logic [RES_W-1:0] result,
    input  logic             align,
    output logic [OUT_W-1:0] data
);
    always_comb begin
        data = '0;
        if (align) data[OUT_W-1 -: RES_W] = result;
        else       data[RES_W-1:0]        = result;
    end
endmodule

// File: rtl/adc_seq.sv
module adc_seq
    import adc_seq_pkg::*;
#(
    parameter int RES_W    = 10,
    parameter int OUT_W    = 16,
    parameter int MUX_W    = 5,
    parameter int REF_W    = 2,
    parameter int NORM_CYC = 13,
    parameter int LONG_CYC = 25,
    localparam int REG_W   = MUX_W + REF_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adc_tick,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic [RES_W-1:0] conv_value,
    output logic [REG_W-1:0] ctrl_rd,
    output logic [REG_W-1:0] sel_rd,
    output logic [OUT_W-1:0] data_out,
    output logic             busy,
    output logic [MUX_W-1:0] act_mux,
    output logic [REF_W-1:0] act_ref
);
    logic ctrl_wr, sel_wr;
    logic [MUX_W-1:0] mux_q, mux_nx;
    logic [REF_W-1:0] ref_q, ref_nx;
    logic align_q, ref_chg;
    logic en, free, start, done;
    logic [RES_W-1:0] result;

    assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
    assign sel_wr  = wr_en && (wr_addr == ADDR_SEL);

    adc_sel_regs #(.MUX_W(MUX_W), .REF_W(REF_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .wr_data(wr_data),
        .mux_q(mux_q), .ref_q(ref_q), .align_q(align_q),
        .mux_nx(mux_nx), .ref_nx(ref_nx), .ref_chg(ref_chg)
    );

    adc_conv_seq #(
        .RES_W(RES_W), .MUX_W(MUX_W), .REF_W(REF_W),
        .NORM_CYC(NORM_CYC), .LONG_CYC(LONG_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(adc_tick),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(wr_data[CTRL_W-1:0]),
        .conv_value(conv_value), .mux_nx(mux_nx), .ref_nx(ref_nx), .ref_chg(ref_chg),
        .en(en), .free(free), .start(start), .done(done), .busy(busy),
        .result(result), .act_mux(act_mux), .act_ref(act_ref)
    );

    adc_res_align #(.RES_W(RES_W), .OUT_W(OUT_W)) u_fmt (
        .result(result), .align(align_q), .data(data_out)
    );

    always_comb begin
        ctrl_rd          = '0;
        ctrl_rd[CTRL_EN] = en;
        ctrl_rd[CTRL_ST] = start;
        ctrl_rd[CTRL_FR] = free;
        ctrl_rd[CTRL_DN] = done;
        sel_rd           = {align_q, ref_q, mux_q};
    end

    p_align_pad_r5: assert property (@(posedge clk) disable iff (!rst_n)
        align_q ? (data_out[OUT_W-RES_W-1:0] == '0) : (data_out[OUT_W-1:RES_W] == '0));
endmodule

// File: tb/sim_adc_seq.sv
module sim_adc_seq;
    logic       clk = 1'b0, rst_n = 1'b0, adc_tick = 1'b1;
    logic       wr_en = 1'b0, wr_addr = 1'b0;
    logic [7:0] wr_data = '0;
    logic [9:0] conv_value = '0;
    logic [7:0] ctrl_rd, sel_rd;
    logic [15:0] data_out;
    logic       busy;
    logic [4:0] act_mux;
    logic [1:0] act_ref;

    int checks = 0, errors = 0;
    bit ended = 1'b0;

    adc_seq u0 (
        .clk(clk), .rst_n(rst_n), .adc_tick(adc_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .conv_value(conv_value),
        .ctrl_rd(ctrl_rd), .sel_rd(sel_rd), .data_out(data_out), .busy(busy),
        .act_mux(act_mux), .act_ref(act_ref)
    );

    always #2 clk = ~clk;

    // {value, align, expected word}
    localparam logic [26:0] VEC [6] = '{
        {10'h3FF, 1'b0, 16'h03FF}, {10'h3FF, 1'b1, 16'hFFC0},
        {10'h001, 1'b0, 16'h0001}, {10'h001, 1'b1, 16'h0040},
        {10'h2A5, 1'b1, 16'hA940}, {10'h15A, 1'b1, 16'h5680}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_ctrl(input logic e, input logic s, input logic f, input logic dn);
        wr(1'b0, {4'b0, dn, f, s, e});
    endtask

    task automatic wr_sel(input logic [4:0] m, input logic [1:0] r, input logic al);
        wr(1'b1, {al, r, m});
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!ctrl_rd[3] && n < 400) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic finish_run();
        ended = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ctrl", 32'(ctrl_rd), 32'h0);
        chk("R1 sel", 32'(sel_rd), 32'h0);
        chk("R1 data", 32'(data_out), 32'h0);
        chk("R1 busy", 32'(busy), 32'h0);
        chk("R1 act", 32'({act_mux, act_ref}), 32'h0);

        // R12 start with enable clear
        wr_ctrl(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R12 ctrl", 32'(ctrl_rd), 32'h0);
        repeat (30) @(negedge clk);
        chk("R12 no done", 32'({busy, ctrl_rd[3]}), 32'h0);

        // first conversion after enable, with a reference change: long
        wr_ctrl(1'b1, 1'b0, 1'b0, 1'b0);
        wr_sel(5'd3, 2'd1, 1'b0);
        conv_value = 10'h123;
        wr_ctrl(1'b1, 1'b1, 1'b0, 1'b0);
        chk("R2 start reads 1", 32'({ctrl_rd[1], busy}), 32'h3);
        wait_done(n);
        chk("R3 first length", 32'(n), 32'd25);
        chk("R2 start cleared R11 done", 32'(ctrl_rd), 32'h9);
        chk("R5 right word", 32'(data_out), 32'h0123);
        chk("R4 act idle", 32'({act_mux, act_ref}), 32'({5'd3, 2'd1}));

        wr_ctrl(1'b1, 1'b0, 1'b0, 1'b1);
        chk("R11 done cleared", 32'(ctrl_rd), 32'h1);
        conv_value = 10'h0AB;
        wr_ctrl(1'b1, 1'b1, 1'b0, 1'b0);
        wait_done(n);
        chk("R2 normal length", 32'(n), 32'd13);
        chk("R2 data", 32'(data_out), 32'h00AB);

        // R5 vector table
        for (int i = 0; i < 6; i++) begin
            conv_value = VEC[i][26:17];
            wr_sel(5'd3, 2'd1, VEC[i][16]);
            wr_ctrl(1'b1, 1'b0, 1'b0, 1'b1);
            wr_ctrl(1'b1, 1'b1, 1'b0, 1'b0);
            wait_done(n);
            chk("R5 length", 32'(n), 32'd13);
            chk("R5 aligned word", 32'(data_out), 32'(VEC[i][15:0]));
        end

        // R6 alignment applies at once, idle and mid-conversion
        wr_sel(5'd3, 2'd1, 1'b0);
        chk("R6 idle realign", 32'(data_out), 32'h015A);
        conv_value = 10'h2C3;
        wr_ctrl(1'b1, 1'b0, 1'b0, 1'b1);
        wr_ctrl(1'b1, 1'b1, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        wr_sel(5'd3, 2'd1, 1'b1);
        chk("R6 busy realign", 32'(data_out), 32'h5680);
        wait_done(n);
        chk("R6 length", 32'(n + 3), 32'd13);
        chk("R5 left word", 32'(data_out), 32'hB0C0);

        // R4 selection write during a conversion
        wr_ctrl(1'b1, 1'b0, 1'b0, 1'b1);
        conv_value = 10'h111;
        wr_ctrl(1'b1, 1'b1, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        wr_sel(5'd7, 2'd2, 1'b0);
        chk("R4 act held", 32'({act_mux, act_ref}), 32'({5'd3, 2'd1}));
        chk("R4 readback", 32'(sel_rd), 32'h47);
        wait_done(n);
        chk("R4 length unchanged", 32'(n + 4), 32'd13);
        chk("R4 act after", 32'({act_mux, act_ref}), 32'({5'd7, 2'd2}));
        chk("R4 data", 32'(data_out), 32'h0111);
        wr_ctrl(1'b1, 1'b0, 1'b0, 1'b1);
        wr_ctrl(1'b1, 1'b1, 1'b0, 1'b0);
        wait_done(n);
        chk("R3 after ref change", 32'(n), 32'd25);

        // R10 start written 0 while busy
        wr_ctrl(1'b1, 1'b0, 1'b0, 1'b1);
        conv_value = 10'h055;
        wr_ctrl(1'b1, 1'b1, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        wr_ctrl(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R10 still busy", 32'({busy, ctrl_rd[1]}), 32'h3);
        wait_done(n);
        chk("R10 length", 32'(n + 5), 32'd13);
        chk("R10 data", 32'(data_out), 32'h0055);

        // R7 disable aborts
        wr_ctrl(1'b1, 1'b0, 1'b0, 1'b1);
        conv_value = 10'h200;
        wr_ctrl(1'b1, 1'b1, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        conv_value = 10'h3C3;
        wr_ctrl(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R7 off", 32'({busy, ctrl_rd}), 32'h0);
        repeat (40) @(negedge clk);
        chk("R7 no done", 32'(ctrl_rd[3]), 32'h0);
        chk("R7 result kept", 32'(data_out), 32'h0055);
        wr_ctrl(1'b1, 1'b1, 1'b0, 1'b0);
        wait_done(n);
        chk("R3 after re-enable", 32'(n), 32'd25);
        chk("R7 new data", 32'(data_out), 32'h03C3);

        // R8 continuous mode
        wr_ctrl(1'b1, 1'b0, 1'b0, 1'b1);
        conv_value = 10'h0F0;
        wr_ctrl(1'b1, 1'b1, 1'b1, 1'b0);
        wait_done(n);
        chk("R8 first length", 32'(n), 32'd13);
        chk("R8 data 1", 32'(data_out), 32'h00F0);
        chk("R8 start held", 32'({busy, ctrl_rd[1]}), 32'h3);
        conv_value = 10'h0F1;
        wr_ctrl(1'b1, 1'b0, 1'b1, 1'b1);
        wait_done(n);
        chk("R8 back to back", 32'(n + 1), 32'd13);
        chk("R8 data 2", 32'(data_out), 32'h00F1);

        // R9 leave continuous mode mid-conversion
        conv_value = 10'h0F2;
        repeat (4) @(negedge clk);
        wr_ctrl(1'b1, 1'b0, 1'b0, 1'b1);
        wait_done(n);
        chk("R9 finishes", 32'(n + 5), 32'd13);
        chk("R9 data", 32'(data_out), 32'h00F2);
        chk("R9 stopped", 32'({busy, ctrl_rd[1]}), 32'h0);
        wr_ctrl(1'b1, 1'b0, 1'b0, 1'b1);
        repeat (40) @(negedge clk);
        chk("R9 no more", 32'({busy, ctrl_rd[3]}), 32'h0);

        finish_run();
    end
endmodule